// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a 4-bit synchronous counter that steps on two separate strobe inputs, one that counts up and one that counts down. A parameter chooses between a decimal sequence (0 to 9) and a full binary sequence (0 to 15). All state sits on one fast system clock. Both strobes pass through a two-flop synchronizer, and their rising edges are found inside the block. A strobe therefore behaves as a slow clock without becoming one.

An active-low load copies a 4-bit preset value into the counter. An active-high clear forces zero and beats every other input. Two active-low terminal outputs, carry and borrow, are gated by the synchronized strobe levels. A wider count is built by wiring one stage's carry to the next stage's up strobe and its borrow to the next stage's down strobe. In decimal mode, the codes 10 to 15 are not part of the sequence and drain back into it under counting.

Top module: `updn_counter`

## Requirements
- R1: A rising edge on `up_stb` while `dn_stb` is high adds one to `cnt` on the third system clock edge after the rise. The count wraps from 15 to 0 in binary mode and from 9 to 0 in decimal mode.
- R2: A rising edge on `dn_stb` while `up_stb` is high subtracts one with the same latency. The count wraps from 0 to 15 in binary mode and from 0 to 9 in decimal mode.
- R3: While `load_n` is low, `cnt` takes `preset` on every system clock edge and strobe edges have no effect.
- R4: While `clr` is high, `cnt` becomes 0 on the next clock edge, whatever `load_n`, `preset` and the strobes do.
- R5: `carry_n` is low exactly while `cnt` is the maximum (9 decimal, 15 binary) and the synchronized `up_stb` is low.
- R6: `borrow_n` is low exactly while `cnt` is 0 and the synchronized `dn_stb` is low.
- R7: In decimal mode an up count moves the illegal codes as 10 to 11, 11 to 6, 12 to 13, 13 to 4, 14 to 15 and 15 to 2.
- R8: In decimal mode a down count moves each illegal code 10 to 15 to the value one lower.
- R9: No count occurs when both strobes rise in the same system cycle, or when one strobe rises while the other is held low.
- R10: Two decimal stages joined carry-to-up and borrow-to-down count together from 00 to 99 and back down to 00.
- R11: After synchronous `rst`, `cnt` is 0 and both `carry_n` and `borrow_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Active-high clear to zero, highest priority |
| load_n | input | 1 | Active-low parallel load |
| preset | input | 4 | Value copied in while loading |
| up_stb | input | 1 | Count-up strobe, acts on rising edge |
| dn_stb | input | 1 | Count-down strobe, acts on rising edge |
| cnt | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal count going up |
| borrow_n | output | 1 | Active-low terminal count going down |

## Verification
The assertions assume that `clr`, `load_n` and `preset` are synchronous to the system clock. They also assume that each strobe stays at a level for several system cycles, so that every edge the synchronizer sees is a real transition. The stimulus drives all inputs on the falling clock edge. It holds each strobe level for at least four cycles, and it leaves a strobe at rest high so that the other strobe's edges are counted. The cascade stage is fed only by the lower stage's terminal outputs, which change on system clock edges.

// File: rtl/updn_pkg.sv
package updn_pkg;

    localparam int CNT_W = 4;

    typedef logic [CNT_W-1:0] count_t;

    typedef enum logic [1:0] {
        MOVE_HOLD = 2'd0,
        MOVE_UP   = 2'd1,
        MOVE_DN   = 2'd2
    } move_e;

    function automatic count_t top_of(input logic dec);
        return dec ? count_t'(9) : count_t'((1 << CNT_W) - 1);
    endfunction

    function automatic count_t step_up(input count_t v, input logic dec);
        if (!dec) return v + count_t'(1);
        case (v)
            count_t'(9):  return count_t'(0);
            count_t'(11): return count_t'(6);
            count_t'(13): return count_t'(4);
            count_t'(15): return count_t'(2);
            default:      return v + count_t'(1);
        endcase
    endfunction

    function automatic count_t step_dn(input count_t v, input logic dec);
        if (dec && v == count_t'(0)) return count_t'(9);
        return v - count_t'(1);
    endfunction

endpackage

// File: rtl/updn_strobe_sync.sv
module updn_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= stb;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], stb};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~prev;

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   load_n,
    input  count_t preset,
    input  move_e  move,
    output count_t cnt
);
    count_t cnt_q;
    count_t cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (!load_n) begin
            cnt_d = preset;
        end else begin
            case (move)
                MOVE_UP: cnt_d = step_up(cnt_q, DECADE);
                MOVE_DN: cnt_d = step_dn(cnt_q, DECADE);
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R4
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0);

    // R3
    load_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load_n) |=> cnt_q == $past(preset));

    // R9
    hold_still_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n && move == MOVE_HOLD) |=> $stable(cnt_q));

    generate
        if (DECADE) begin : g_dec_chk
            // R7
            legal_stays_chk: assert property (@(posedge clk) disable iff (rst)
                (!clr && load_n && cnt_q <= count_t'(9)) |=> cnt_q <= count_t'(9));
        end
    endgenerate
endmodule

// File: rtl/updn_term_gen.sv
module updn_term_gen
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  count_t cnt,
    input  logic   up_lvl,
    input  logic   dn_lvl,
    output logic   carry_n,
    output logic   borrow_n
);
    localparam count_t TOP = top_of(DECADE);

    always_comb begin
        carry_n  = !((cnt == TOP) && !up_lvl);
        borrow_n = !((cnt == '0)  && !dn_lvl);
    end
endmodule

// File: rtl/updn_counter.sv
module updn_counter
    import updn_pkg::*;
#(
    parameter bit DECADE      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load_n,
    input  logic [CNT_W-1:0] preset,
    input  logic             up_stb,
    input  logic             dn_stb,
    output logic [CNT_W-1:0] cnt,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam count_t TOP = top_of(DECADE);

    logic  up_lvl, up_rise, dn_lvl, dn_rise;
    move_e move;

    updn_strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk(clk), .rst(rst), .stb(up_stb), .lvl(up_lvl), .rise(up_rise)
    );

    updn_strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk(clk), .rst(rst), .stb(dn_stb), .lvl(dn_lvl), .rise(dn_rise)
    );

    always_comb begin
        move = MOVE_HOLD;
        if (up_rise && dn_lvl && !dn_rise)      move = MOVE_UP;
        else if (dn_rise && up_lvl && !up_rise) move = MOVE_DN;
    end

    updn_count_core #(.DECADE(DECADE)) u_core (
        .clk(clk), .rst(rst), .clr(clr), .load_n(load_n),
        .preset(preset), .move(move), .cnt(cnt)
    );

    updn_term_gen #(.DECADE(DECADE)) u_term (
        .cnt(cnt), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
        .carry_n(carry_n), .borrow_n(borrow_n)
    );

    // R9
    dual_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (up_rise && dn_rise && load_n && !clr) |=> $stable(cnt));

    // R5
    carry_at_top_chk: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> cnt == TOP);

    // R6
    borrow_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !borrow_n |-> cnt == '0);

    // R1
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (up_rise && dn_lvl && !dn_rise && load_n && !clr)
            |=> cnt == step_up($past(cnt), DECADE));
endmodule

// File: tb/updn_counter_tb_top.sv
`timescale 1ns/1ps
module updn_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] preset = 4'd0;
    logic       up_stb = 1'b1;
    logic       dn_stb = 1'b1;

    logic [3:0] cnt_dec, cnt_bin, cnt_hi;
    logic       cy_dec, bw_dec, cy_bin, bw_bin, cy_hi, bw_hi;

    int n_chk  = 0;
    int n_fail = 0;
    int m_dec  = 0;
    int m_bin  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    updn_counter #(.DECADE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .preset(preset),
        .up_stb(up_stb), .dn_stb(dn_stb),
        .cnt(cnt_dec), .carry_n(cy_dec), .borrow_n(bw_dec)
    );

    updn_counter #(.DECADE(1'b0)) dut_bin (
        .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .preset(preset),
        .up_stb(up_stb), .dn_stb(dn_stb),
        .cnt(cnt_bin), .carry_n(cy_bin), .borrow_n(bw_bin)
    );

    updn_counter #(.DECADE(1'b1)) dut_hi (
        .clk(clk), .rst(rst), .clr(clr), .load_n(1'b1), .preset(4'd0),
        .up_stb(cy_dec), .dn_stb(bw_dec),
        .cnt(cnt_hi), .carry_n(cy_hi), .borrow_n(bw_hi)
    );

    function automatic int ref_up(input int v, input bit dec);
        if (!dec) return (v + 1) % 16;
        if (v == 9)  return 0;
        if (v == 11) return 6;
        if (v == 13) return 4;
        if (v == 15) return 2;
        return v + 1;
    endfunction

    function automatic int ref_dn(input int v, input bit dec);
        if (v == 0) return dec ? 9 : 15;
        return v - 1;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_up();
        up_stb = 1'b0; tick(4);
        up_stb = 1'b1; tick(8);
        m_dec = ref_up(m_dec, 1'b1);
        m_bin = ref_up(m_bin, 1'b0);
    endtask

    task automatic pulse_dn();
        dn_stb = 1'b0; tick(4);
        dn_stb = 1'b1; tick(8);
        m_dec = ref_dn(m_dec, 1'b1);
        m_bin = ref_dn(m_bin, 1'b0);
    endtask

    task automatic load_both(input int v);
        preset = 4'(v); load_n = 1'b0; tick(2);
        load_n = 1'b1; tick(1);
        m_dec = v; m_bin = v;
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(3); rst = 1'b0; tick(1);
        chk("R11 cnt dec", cnt_dec, 0);
        chk("R11 cnt bin", cnt_bin, 0);
        chk("R11 carry_n", cy_dec, 1);
        chk("R11 borrow_n", bw_dec, 1);
        m_dec = 0; m_bin = 0;
    endtask

    task automatic t_wrap_up();
        load_both(7);
        for (int i = 0; i < 10; i++) begin
            pulse_up();
            chk("R1 up dec", cnt_dec, m_dec);
            chk("R1 up bin", cnt_bin, m_bin);
        end
        load_both(9);
        up_stb = 1'b0; tick(4);
        chk("R5 carry low at 9 dec", cy_dec, 0);
        chk("R5 carry high at 9 bin", cy_bin, 1);
        up_stb = 1'b1; tick(8);
        m_dec = 0; m_bin = 10;
        chk("R5 carry back high", cy_dec, 1);
        chk("R1 wrap 9 to 0", cnt_dec, 0);
        load_both(15);
        up_stb = 1'b0; tick(4);
        chk("R5 carry low at 15 bin", cy_bin, 0);
        up_stb = 1'b1; tick(8);
        m_dec = 2; m_bin = 0;
        chk("R1 wrap 15 to 0 bin", cnt_bin, 0);
    endtask

    task automatic t_wrap_dn();
        load_both(0);
        dn_stb = 1'b0; tick(4);
        chk("R6 borrow low dec", bw_dec, 0);
        chk("R6 borrow low bin", bw_bin, 0);
        dn_stb = 1'b1; tick(8);
        m_dec = 9; m_bin = 15;
        chk("R2 wrap 0 to 9", cnt_dec, 9);
        chk("R2 wrap 0 to 15", cnt_bin, 15);
        chk("R6 borrow back high", bw_dec, 1);
        for (int i = 0; i < 12; i++) begin
            pulse_dn();
            chk("R2 down dec", cnt_dec, m_dec);
            chk("R2 down bin", cnt_bin, m_bin);
        end
    endtask

    task automatic t_illegal();
        for (int v = 10; v < 16; v++) begin
            load_both(v);
            pulse_up();
            chk("R7 illegal up dec", cnt_dec, m_dec);
            chk("R1 up bin", cnt_bin, m_bin);
            load_both(v);
            pulse_dn();
            chk("R8 illegal down dec", cnt_dec, v - 1);
            chk("R2 down bin", cnt_bin, m_bin);
        end
    endtask

    task automatic t_load();
        preset = 4'd5; load_n = 1'b0; tick(2);
        up_stb = 1'b0; tick(4); up_stb = 1'b1; tick(8);
        chk("R3 edge ignored dec", cnt_dec, 5);
        chk("R3 edge ignored bin", cnt_bin, 5);
        preset = 4'd3; tick(2);
        chk("R3 reload each cycle", cnt_dec, 3);
        load_n = 1'b1; tick(1);
        m_dec = 3; m_bin = 3;
    endtask

    task automatic t_clear();
        clr = 1'b1; load_n = 1'b0; preset = 4'd7; tick(2);
        chk("R4 clear over load dec", cnt_dec, 0);
        chk("R4 clear over load bin", cnt_bin, 0);
        up_stb = 1'b0; tick(4); up_stb = 1'b1; tick(8);
        chk("R4 clear over strobe", cnt_dec, 0);
        clr = 1'b0; load_n = 1'b1; tick(1);
        m_dec = 0; m_bin = 0;
    endtask

    task automatic t_blocked();
        load_both(4);
        up_stb = 1'b0; dn_stb = 1'b0; tick(4);
        up_stb = 1'b1; dn_stb = 1'b1; tick(8);
        chk("R9 dual rise dec", cnt_dec, 4);
        chk("R9 dual rise bin", cnt_bin, 4);
        dn_stb = 1'b0; tick(4);
        up_stb = 1'b0; tick(4); up_stb = 1'b1; tick(8);
        chk("R9 up edge with dn low", cnt_dec, 4);
        dn_stb = 1'b1; tick(8);
        m_dec = 3; m_bin = 3;
        chk("R2 dn release counts", cnt_dec, 3);
    endtask

    task automatic t_cascade();
        clr = 1'b1; tick(2); clr = 1'b0; tick(1);
        m_dec = 0; m_bin = 0;
        for (int i = 1; i <= 99; i++) begin
            pulse_up();
            chk("R10 cascade up", int'(cnt_hi) * 10 + int'(cnt_dec), i);
        end
        for (int i = 98; i >= 0; i--) begin
            pulse_dn();
            chk("R10 cascade down", int'(cnt_hi) * 10 + int'(cnt_dec), i);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(1);
        t_reset();
        t_wrap_up();
        t_wrap_dn();
        t_illegal();
        t_load();
        t_clear();
        t_blocked();
        t_cascade();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule